// File: doc/BRIEF.md
# Byte/Word Integer and Decimal ALU with Condition Flags

This is a purely combinational arithmetic/logic unit for a 16-bit processor datapath. Each cycle the execute stage presents a source operand, a destination operand, the current carry flag, a 4-bit operation code and a byte/word select. The unit returns the result, the four condition flags (carry, zero, negative, overflow), a write-enable that says whether the result should go back to the destination, and a per-flag update mask that says which flags the status register should take.

In byte mode only the low eight bits of each operand take part, the upper half of the result is forced to zero, and carry, sign and overflow are all taken at bit 7. The unit supports binary add and subtract with and without carry-in, a packed-BCD add with carry, compare and bit-test operations that only produce flags, bitwise and/or/xor/bit-clear, an arithmetic and a through-carry right shift, a byte swap and a sign extension. Operand fetch, stack handling and branching belong to other stages. The block has no clock and no state, so the house state-machine layout reduces here to one decode process per submodule.

Top module: `alu16_core`

## Requirements
- R1: Operation codes on `op_i` are MOV=0, ADD=1, ADDC=2, SUB=3, SUBC=4, CMP=5, DADD=6, TEST=7, CLRB=8, SETB=9, XOR=10, AND=11, RORC=12, SWAP=13, SRA=14, SEXT=15. `wr_en_o` is 0 for CMP and TEST and 1 for all other codes.
- R2: ADD gives dst+src and ADDC gives dst+src+`cin_i`. C is the carry out of the top bit of the selected width, and V is set when both operands have the same sign and the result sign differs.
- R3: SUB and CMP give dst+NOT src+1 and SUBC gives dst+NOT src+`cin_i`. C=1 means no borrow, and V is signed overflow of that sum. CMP with equal operands gives Z=1 and C=1.
- R4: DADD adds src, dst and `cin_i` as packed BCD digits (2 digits in byte mode, 4 in word mode, valid BCD inputs). C is the decimal carry out of the top digit. The mask updates C, Z and N but not V.
- R5: AND and TEST give src AND dst, and XOR gives src XOR dst. For these operations C = NOT Z. V is 0 for AND and TEST, and for XOR V is set only when both operands are negative.
- R6: MOV passes src, CLRB gives NOT src AND dst, and SETB gives src OR dst. The flag mask is 0 for all three.
- R7: SRA shifts dst right and keeps its sign bit. RORC shifts dst right with `cin_i` entering the top bit. For both, C takes the old bit 0 and V=0.
- R8: SWAP exchanges the two bytes of the full 16-bit dst and updates no flags. SEXT copies dst bit 7 into bits 15..8 and sets flags from the 16-bit result (C = NOT Z, V=0). Both ignore `byte_i`.
- R9: In byte mode, except for SWAP and SEXT, result bits 15..8 are zero, operand bits 15..8 have no effect, and C, N and V are taken at bit 7.
- R10: N is the top bit of the result at the flag width and Z is set when the result is zero. `flag_mask_o` bits are [0]=C, [1]=Z, [2]=N, [3]=V. A flag output whose mask bit is 0 reads 0.
- R11: SRA, RORC, SWAP and SEXT use only dst, and `src_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| cin_i | input | 1 | Carry flag entering the operation |
| op_i | input | 4 | Operation code (see R1) |
| byte_i | input | 1 | 1 selects 8-bit operation |
| res_o | output | 16 | Result |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| wr_en_o | output | 1 | Result should be written to the destination |
| flag_mask_o | output | 4 | Flags to update: [0]C [1]Z [2]N [3]V |

## Verification
The bench targets several corner cases. The first is signed overflow at 0x7FFF+1 and at 0x80+0x80 in byte mode; a design that took V from bit 15 in byte mode would miss the byte case. The second is borrow polarity on 0-1 and on equal operands; an inverted carry would report a borrow where none happened. The third is the decimal chain 9999+1 and 0999+1, where a missing digit correction or a dropped digit carry leaves hex digits in the result or loses C. The bench also drives garbage into the upper operand bytes in byte mode and into `src_i` for the single-operand codes, so leaking upper bits or a swapped operand shows up directly in `res_o`. It checks that flag outputs read zero wherever the mask is clear.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADDC = 4'd2,
        OP_SUB  = 4'd3,
        OP_SUBC = 4'd4,
        OP_CMP  = 4'd5,
        OP_DADD = 4'd6,
        OP_TEST = 4'd7,
        OP_CLRB = 4'd8,
        OP_SETB = 4'd9,
        OP_XOR  = 4'd10,
        OP_AND  = 4'd11,
        OP_RORC = 4'd12,
        OP_SWAP = 4'd13,
        OP_SRA  = 4'd14,
        OP_SEXT = 4'd15
    } alu_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_W = 4;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  alu_op_e      op_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam int H   = W / 2;
    localparam int ND  = W / 4;
    localparam int NDH = H / 4;

    logic         inv_b;
    logic         cc;
    logic [W-1:0] bx;
    logic [H:0]   lo;
    logic [W-H:0] hi;
    logic [W-1:0] bin;
    logic [W-1:0] dsum;

    always_comb begin
        inv_b = op_i inside {OP_SUB, OP_SUBC, OP_CMP};
        unique case (op_i)
            OP_ADD:          cc = 1'b0;
            OP_SUB, OP_CMP:  cc = 1'b1;
            default:         cc = cin_i;
        endcase
        bx  = inv_b ? ~b_i : b_i;
        lo  = {1'b0, a_i[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, cc};
        hi  = {1'b0, a_i[W-1:H]} + {1'b0, bx[W-1:H]} + {{(W-H){1'b0}}, lo[H]};
        bin = {hi[W-H-1:0], lo[H-1:0]};
    end

    for (genvar g = 0; g < ND; g++) begin : g_dig
        logic       cin_d;
        logic       cout_d;
        logic [4:0] raw;
        if (g == 0) begin : g_first
            assign cin_d = cin_i;
        end else begin : g_next
            assign cin_d = g_dig[g-1].cout_d;
        end
        assign raw    = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, cin_d};
        assign cout_d = raw > 5'd9;
        assign dsum[4*g +: 4] = cout_d ? raw[3:0] + 4'd6 : raw[3:0];
    end

    always_comb begin
        if (op_i == OP_DADD) begin
            sum_o   = dsum;
            carry_o = byte_i ? g_dig[NDH-1].cout_d : g_dig[ND-1].cout_d;
            ovf_o   = 1'b0;
        end else begin
            sum_o   = bin;
            carry_o = byte_i ? lo[H] : hi[W-H];
            if (byte_i)
                ovf_o = (a_i[H-1] == bx[H-1]) && (bin[H-1] != a_i[H-1]);
            else
                ovf_o = (a_i[W-1] == bx[W-1]) && (bin[W-1] != a_i[W-1]);
        end
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] d_full_i,
    input  logic         cin_i,
    input  alu_op_e      op_i,
    input  logic         byte_i,
    output logic [W-1:0] res_o,
    output logic         sh_c_o
);
    localparam int H = W / 2;

    logic [W-1:0] sr;
    logic         top_in;

    always_comb begin
        top_in = (op_i == OP_SRA) ? (byte_i ? d_i[H-1] : d_i[W-1]) : cin_i;
        sr     = d_i >> 1;
        if (byte_i) sr[H-1] = top_in;
        else        sr[W-1] = top_in;
    end

    always_comb begin
        unique case (op_i)
            OP_MOV:           res_o = s_i;
            OP_AND, OP_TEST:  res_o = s_i & d_i;
            OP_CLRB:          res_o = ~s_i & d_i;
            OP_SETB:          res_o = s_i | d_i;
            OP_XOR:           res_o = s_i ^ d_i;
            OP_SRA, OP_RORC:  res_o = sr;
            OP_SWAP:          res_o = {d_full_i[H-1:0], d_full_i[W-1:H]};
            OP_SEXT:          res_o = {{(W-H){d_full_i[H-1]}}, d_full_i[H-1:0]};
            default:          res_o = '0;
        endcase
        sh_c_o = d_i[0];
    end

    always_comb begin
        if (op_i == OP_SRA) begin
            p_sra_sign_r7: assert (byte_i ? (res_o[H-1] == d_i[H-1]) : (res_o[W-1] == d_i[W-1]))
                else $error("SRA lost the sign bit");
        end
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op_i,
    input  logic         byte_i,
    input  logic [W-1:0] res_i,
    input  logic         ar_c_i,
    input  logic         ar_v_i,
    input  logic         sh_c_i,
    input  logic         s_msb_i,
    input  logic         d_msb_i,
    output logic         c_o,
    output logic         z_o,
    output logic         n_o,
    output logic         v_o,
    output logic [FLG_W-1:0] mask_o
);
    localparam int H = W / 2;

    logic wide;
    logic z_raw;
    logic n_raw;
    logic c_raw;
    logic v_raw;

    always_comb begin
        wide  = !byte_i || (op_i inside {OP_SWAP, OP_SEXT});
        z_raw = (res_i == '0);
        n_raw = wide ? res_i[W-1] : res_i[H-1];
        unique case (op_i)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                c_raw = ar_c_i; v_raw = ar_v_i; mask_o = 4'b1111;
            end
            OP_DADD: begin
                c_raw = ar_c_i; v_raw = 1'b0; mask_o = 4'b0111;
            end
            OP_AND, OP_TEST, OP_SEXT: begin
                c_raw = !z_raw; v_raw = 1'b0; mask_o = 4'b1111;
            end
            OP_XOR: begin
                c_raw = !z_raw; v_raw = s_msb_i & d_msb_i; mask_o = 4'b1111;
            end
            OP_SRA, OP_RORC: begin
                c_raw = sh_c_i; v_raw = 1'b0; mask_o = 4'b1111;
            end
            default: begin
                c_raw = 1'b0; v_raw = 1'b0; mask_o = 4'b0000;
            end
        endcase
        c_o = c_raw & mask_o[FLG_C];
        z_o = z_raw & mask_o[FLG_Z];
        n_o = n_raw & mask_o[FLG_N];
        v_o = v_raw & mask_o[FLG_V];
    end

    always_comb begin
        if (op_i inside {OP_AND, OP_TEST, OP_XOR, OP_SEXT}) begin
            p_logic_carry_r5: assert (c_o == !z_o)
                else $error("logic op carry is not NOT zero");
        end
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    input  logic         cin_i,
    input  logic [3:0]   op_i,
    input  logic         byte_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         z_o,
    output logic         n_o,
    output logic         v_o,
    output logic         wr_en_o,
    output logic [FLG_W-1:0] flag_mask_o
);
    localparam int H = W / 2;

    alu_op_e      op;
    logic [W-1:0] s_eff;
    logic [W-1:0] d_eff;
    logic [W-1:0] ar_sum;
    logic         ar_c;
    logic         ar_v;
    logic [W-1:0] lg_res;
    logic         sh_c;
    logic [W-1:0] raw;
    logic         s_msb;
    logic         d_msb;

    always_comb begin
        op      = alu_op_e'(op_i);
        s_eff   = byte_i ? {{(W-H){1'b0}}, src_i[H-1:0]} : src_i;
        d_eff   = byte_i ? {{(W-H){1'b0}}, dst_i[H-1:0]} : dst_i;
        s_msb   = byte_i ? s_eff[H-1] : s_eff[W-1];
        d_msb   = byte_i ? d_eff[H-1] : d_eff[W-1];
        wr_en_o = !(op inside {OP_CMP, OP_TEST});
        raw     = (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_DADD})
                  ? ar_sum : lg_res;
        if (byte_i && !(op inside {OP_SWAP, OP_SEXT}))
            res_o = {{(W-H){1'b0}}, raw[H-1:0]};
        else
            res_o = raw;
    end

    alu16_arith #(.W(W)) u_arith (
        .a_i     (d_eff),
        .b_i     (s_eff),
        .cin_i   (cin_i),
        .op_i    (op),
        .byte_i  (byte_i),
        .sum_o   (ar_sum),
        .carry_o (ar_c),
        .ovf_o   (ar_v)
    );

    alu16_logic #(.W(W)) u_logic (
        .s_i      (s_eff),
        .d_i      (d_eff),
        .d_full_i (dst_i),
        .cin_i    (cin_i),
        .op_i     (op),
        .byte_i   (byte_i),
        .res_o    (lg_res),
        .sh_c_o   (sh_c)
    );

    alu16_flags #(.W(W)) u_flags (
        .op_i    (op),
        .byte_i  (byte_i),
        .res_i   (res_o),
        .ar_c_i  (ar_c),
        .ar_v_i  (ar_v),
        .sh_c_i  (sh_c),
        .s_msb_i (s_msb),
        .d_msb_i (d_msb),
        .c_o     (c_o),
        .z_o     (z_o),
        .n_o     (n_o),
        .v_o     (v_o),
        .mask_o  (flag_mask_o)
    );

    always_comb begin
        if (!wr_en_o) begin
            p_nowrite_flags_r1: assert (flag_mask_o == 4'b1111)
                else $error("flag-only op does not update all flags");
        end
        if (op == OP_CMP && s_eff == d_eff) begin
            p_cmp_equal_r3: assert (z_o && c_o)
                else $error("compare of equal operands lacks Z or C");
        end
        if (byte_i && !(op inside {OP_SWAP, OP_SEXT})) begin
            p_upper_clear_r9: assert (res_o[W-1:H] == '0)
                else $error("byte result has upper bits set");
        end
        if (op == OP_SEXT) begin
            p_sext_fill_r8: assert (res_o[W-1:H] == {(W-H){res_o[H-1]}})
                else $error("sign extension fill wrong");
        end
    end
endmodule

// File: tb/tb_alu16_core.sv
module tb_alu16_core;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic [15:0] src_i, dst_i;
    logic        cin_i, byte_i;
    logic [3:0]  op_i;
    logic [15:0] res_o;
    logic        c_o, z_o, n_o, v_o, wr_en_o;
    logic [3:0]  flag_mask_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    alu16_core dut (
        .src_i(src_i), .dst_i(dst_i), .cin_i(cin_i), .op_i(op_i), .byte_i(byte_i),
        .res_o(res_o), .c_o(c_o), .z_o(z_o), .n_o(n_o), .v_o(v_o),
        .wr_en_o(wr_en_o), .flag_mask_o(flag_mask_o)
    );

    function automatic int bcd_val(input int x, input int nd);
        int acc = 0;
        int mul = 1;
        for (int i = 0; i < nd; i++) begin
            acc += ((x >> (4*i)) & 15) * mul;
            mul *= 10;
        end
        return acc;
    endfunction

    function automatic int to_bcd(input int x, input int nd);
        int acc = 0;
        int t = x;
        for (int i = 0; i < nd; i++) begin
            acc |= (t % 10) << (4*i);
            t /= 10;
        end
        return acc;
    endfunction

    // Behavioural model built directly from the requirements.
    function automatic void model(input int op, input int s, input int d, input int ci, input int bm,
                                  output int r, output int c, output int z, output int n,
                                  output int v, output int we, output int mk);
        int w, modv, hb, sm, dm, t, ns, lim;
        w    = (op == 13 || op == 15) ? 16 : (bm != 0 ? 8 : 16);
        modv = 1 << w;
        hb   = 1 << (w - 1);
        sm   = s % modv;
        dm   = d % modv;
        c = 0; v = 0; mk = 15;
        we = (op == 5 || op == 7) ? 0 : 1;
        case (op)
            1, 2: begin
                t = dm + sm + (op == 2 ? ci : 0);
                r = t % modv; c = (t >= modv);
                v = ((dm & hb) == (sm & hb)) && ((r & hb) != (dm & hb));
            end
            3, 4, 5: begin
                ns = (modv - 1) - sm;
                t = dm + ns + (op == 4 ? ci : 1);
                r = t % modv; c = (t >= modv);
                v = ((dm & hb) == (ns & hb)) && ((r & hb) != (dm & hb));
            end
            6: begin
                lim = (w == 8) ? 100 : 10000;
                t = bcd_val(dm, w/4) + bcd_val(sm, w/4) + ci;
                c = (t >= lim); r = to_bcd(t % lim, w/4); mk = 7;
            end
            7, 11: begin r = dm & sm; c = (r != 0); end
            10: begin r = dm ^ sm; c = (r != 0); v = ((dm & hb) != 0) && ((sm & hb) != 0); end
            0:  begin r = sm; mk = 0; end
            8:  begin r = (~sm) & dm & (modv - 1); mk = 0; end
            9:  begin r = sm | dm; mk = 0; end
            14: begin r = (dm >> 1) | (dm & hb); c = dm & 1; end
            12: begin r = (dm >> 1) | (ci != 0 ? hb : 0); c = dm & 1; end
            13: begin r = ((d & 255) << 8) | ((d >> 8) & 255); mk = 0; end
            default: begin
                r = ((d & 128) != 0) ? ((d & 255) | 16'hFF00) : (d & 255);
                c = (r != 0);
            end
        endcase
        n = ((r & hb) != 0) ? 1 : 0;
        z = (r == 0) ? 1 : 0;
        if (mk == 0) begin c = 0; z = 0; n = 0; end
        if (mk != 15) v = 0;
    endfunction

    task automatic apply(input int op, input int s, input int d, input int ci, input int bm, input string tag);
        int er, ec, ez, en, ev, ew, em;
        @(posedge clk);
        #1;
        op_i = op[3:0]; src_i = s[15:0]; dst_i = d[15:0]; cin_i = ci[0]; byte_i = bm[0];
        @(negedge clk);
        model(op, s, d, ci, bm, er, ec, ez, en, ev, ew, em);
        n_cmp++;
        if (int'(res_o) != er || int'(c_o) != ec || int'(z_o) != ez || int'(n_o) != en ||
            int'(v_o) != ev || int'(wr_en_o) != ew || int'(flag_mask_o) != em) begin
            n_bad++;
            $display("FAIL %s op=%0d s=%h d=%h ci=%0d b=%0d: got res=%h c%0d z%0d n%0d v%0d we%0d m%h exp res=%h c%0d z%0d n%0d v%0d we%0d m%h",
                     tag, op, s[15:0], d[15:0], ci, bm, res_o, c_o, z_o, n_o, v_o, wr_en_o, flag_mask_o,
                     er[15:0], ec, ez, en, ev, ew, em[3:0]);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            1, 2:          return "R2";
            3, 4, 5:       return "R3";
            6:             return "R4";
            7, 10, 11:     return "R5";
            0, 8, 9:       return "R6";
            12, 14:        return "R7";
            default:       return "R8";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        op_i = 0; src_i = 0; dst_i = 0; cin_i = 0; byte_i = 0;
        // R1 / R6: idle MOV of zero, flags masked off, write enabled
        apply(0, 0, 16'h1234, 1, 0, "R1 R6");
        // R2: word and byte overflow / carry
        apply(1, 1, 16'h7FFF, 0, 0, "R2");
        apply(1, 1, 16'hFFFF, 0, 0, "R2");
        apply(2, 1, 1, 1, 0, "R2");
        apply(1, 16'h1280, 16'hAB80, 0, 1, "R2 R9");
        apply(1, 16'h3401, 16'h12FF, 0, 1, "R9");
        // R3: borrow polarity, equal compare (no write, R1)
        apply(3, 5, 5, 0, 0, "R3");
        apply(3, 1, 0, 0, 0, "R3");
        apply(4, 1, 3, 0, 0, "R3");
        apply(5, 16'h8000, 16'h8000, 0, 0, "R3 R1");
        apply(5, 1, 16'h8000, 0, 0, "R3 R1");
        // R4: decimal carry chain
        apply(6, 1, 16'h0999, 0, 0, "R4");
        apply(6, 1, 16'h9999, 0, 0, "R4");
        apply(6, 16'h0001, 16'h0099, 0, 1, "R4 R9");
        apply(6, 16'h0045, 16'h0054, 1, 0, "R4");
        // R5: logic flags, TEST does not write (R1)
        apply(7, 16'h00F0, 16'h0F00, 0, 0, "R5 R1");
        apply(10, 16'h8001, 16'h8000, 0, 0, "R5");
        apply(10, 16'hFF80, 16'h0080, 0, 1, "R5 R9");
        // R6
        apply(8, 16'h00FF, 16'hFFFF, 1, 0, "R6");
        apply(9, 16'h0F00, 16'h00F0, 1, 0, "R6");
        // R7 / R11: shifts with garbage in src
        apply(14, 16'hDEAD, 16'h8001, 0, 0, "R7 R11");
        apply(12, 16'hBEEF, 16'h0002, 1, 1, "R7 R11");
        apply(12, 16'h1234, 16'h0001, 0, 0, "R7 R11");
        // R8 / R11: byte mode ignored for SWAP and SEXT
        apply(13, 16'hFFFF, 16'h1234, 0, 1, "R8 R11");
        apply(15, 16'h5555, 16'h1280, 0, 1, "R8 R11");
        apply(15, 16'h0000, 16'hFF00, 0, 0, "R8 R10");
        // Random sweep over all codes, both widths (R9, R10 via model)
        for (int i = 0; i < 3000; i++) begin
            int op, s, d;
            op = $urandom_range(0, 15);
            s  = $urandom_range(0, 65535);
            d  = $urandom_range(0, 65535);
            if (op == 6) begin
                s = to_bcd(s % 10000, 4);
                d = to_bcd(d % 10000, 4);
            end
            apply(op, s, d, $urandom_range(0, 1), $urandom_range(0, 1), tag_of(op));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule